// File: doc/BRIEF.md
# Linked control-block DMA sequencer

This block drives a single DMA channel through a chain of command descriptors kept in memory. Software writes the address of the first descriptor and pulses `start`. The sequencer reads the six-word descriptor over a word-wide memory master port, one read in flight at a time, in ascending address order. It presents the fields to an external transfer generator and pulses `xfer_start`. It waits for `xfer_done`, records completion in sticky flags and, when the descriptor asks for it, raises an interrupt. It then follows the descriptor's link word. The chain ends when the link word is zero or when the channel's enable input is low at a descriptor boundary. At that point the channel reports paused, not idle.

The controller states are: `ST_IDLE` (waiting for start), `ST_CHECK` (decides whether another descriptor is processed), `ST_FETCH` (six reads in flight one after another), `ST_LAUNCH` (one-cycle transfer kick), `ST_WAIT` (transfer generator busy) and `ST_RETIRE` (flags set, link followed). The transitions are: idle→check on start; check→fetch when enabled and the address is nonzero, otherwise check→idle (stop); fetch→launch when the sixth word arrives; launch→wait always; wait→retire on done; retire→check always.

Top module: `cb_chain_dma`

## Requirements
- R1: After reset, `active`, `paused`, `end_flag`, `int_flag`, `irq`, `mem_req` and `xfer_start` are 0, and `cur_cb_addr` is 0.
- R2: A `start` pulse while `active` is 0 sets `active` to 1 and clears `paused` on the next edge. A `cb_addr_wr` write loads `cur_cb_addr` only while `active` is 0; while active it has no effect.
- R3: A descriptor fetch issues exactly six reads (`mem_we`=0) at the descriptor address +0, +4, +8, +12, +16 and +20, in that order. A new `mem_req` is issued only after the previous read returned `mem_rvalid`, and `mem_req` never lasts two consecutive cycles.
- R4: The six fetched words appear, in fetch order, on `cb_info`, `cb_src`, `cb_dst`, `cb_len`, `cb_stride` and `cb_next`, and hold their values until the next fetch.
- R5: After the sixth word arrives, `xfer_start` pulses for exactly one cycle with the descriptor fields valid. The sequencer then waits for `xfer_done` before doing anything else.
- R6: When a descriptor's transfer completes, `end_flag` is set.
- R7: When a completed descriptor has `cb_info` bit 0 set, `int_flag` and `irq` are set. When bit 0 is clear, they are left as they were.
- R8: After each descriptor, `cur_cb_addr` takes the fetched link word. Processing repeats while that word is nonzero.
- R9: `chan_en` is sampled only between descriptors. If it is 0 when a descriptor would begin, including at start, nothing is fetched. A descriptor already begun always completes.
- R10: When the chain stops, `active` goes to 0 and `paused` goes to 1 in the same edge.
- R11: A `clr_end` pulse clears `end_flag`; a `clr_int` pulse clears `int_flag` and `irq`. Each leaves the other flag unchanged. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable, sampled between descriptors |
| start | input | 1 | Start pulse, accepted while inactive |
| cb_addr_wr | input | 1 | Write strobe for the descriptor address |
| cb_addr_in | input | 32 | Descriptor address to load |
| clr_end | input | 1 | Clear the end flag |
| clr_int | input | 1 | Clear the interrupt flag and line |
| active | output | 1 | Chain running |
| paused | output | 1 | Chain stopped after running |
| end_flag | output | 1 | Sticky descriptor-complete flag |
| int_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request line |
| cur_cb_addr | output | 32 | Current descriptor address |
| cb_info | output | 32 | Fetched transfer info word |
| cb_src | output | 32 | Fetched source address |
| cb_dst | output | 32 | Fetched destination address |
| cb_len | output | 32 | Fetched transfer length |
| cb_stride | output | 32 | Fetched stride word |
| cb_next | output | 32 | Fetched link word |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write enable (always 0) |
| mem_wdata | output | 32 | Memory write data (always 0) |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Memory read response valid |
| xfer_start | output | 1 | Transfer kick pulse |
| xfer_done | input | 1 | Transfer completion pulse |

## Verification
The assertions check several rules on every cycle. They check that a read request never repeats back to back and that requests are aligned reads. They check that the transfer kick is a single cycle and that no request is made while the channel is inactive. They also check that stopping always leaves the channel paused and that a rising interrupt comes only from a descriptor with bit 0 set together with the end flag. Other behaviour only the scenarios can show: the exact order of fetch addresses, the field mapping, the walk along the link words, and that a descriptor under way finishes after enable drops. The same holds for the effect of writes ignored during a run and of the clear pulses.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    localparam int CB_WORDS = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_LAUNCH,
        ST_WAIT,
        ST_RETIRE
    } seq_state_e;

    // word positions inside a descriptor, in fetch order
    localparam int W_INFO   = 0;
    localparam int W_SRC    = 1;
    localparam int W_DST    = 2;
    localparam int W_LEN    = 3;
    localparam int W_STRIDE = 4;
    localparam int W_NEXT   = 5;
endpackage

// File: rtl/cbd_fetch.sv
module cbd_fetch #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int NW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [AW-1:0]          base,
    output logic                   mem_req,
    output logic [AW-1:0]          mem_addr,
    input  logic [DW-1:0]          mem_rdata,
    input  logic                   mem_rvalid,
    output logic                   done,
    output logic [NW-1:0][DW-1:0]  words
);
    localparam int IW = (NW > 1) ? $clog2(NW) : 1;
    localparam int BYTES_LOG = $clog2(DW / 8);

    logic [IW-1:0] idx;
    logic          busy;
    logic          waiting;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            busy    <= 1'b0;
            waiting <= 1'b0;
            base_q  <= '0;
            done    <= 1'b0;
            words   <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy    <= 1'b1;
                idx     <= '0;
                waiting <= 1'b0;
                base_q  <= base;
            end else if (busy) begin
                if (!waiting) begin
                    waiting <= 1'b1;
                end else if (mem_rvalid) begin
                    words[idx] <= mem_rdata;
                    waiting    <= 1'b0;
                    if (idx == IW'(NW - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    assign mem_req  = busy && !waiting;
    assign mem_addr = base_q + (AW'(idx) << BYTES_LOG);

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);  // R3
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[BYTES_LOG-1:0] == '0));  // R3
endmodule

// File: rtl/cbd_flags.sv
module cbd_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_end,
    input  logic set_int,
    input  logic clr_end,
    input  logic clr_int,
    output logic end_flag,
    output logic int_flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_flag <= 1'b0;
            int_flag <= 1'b0;
        end else begin
            if (set_end)      end_flag <= 1'b1;
            else if (clr_end) end_flag <= 1'b0;
            if (set_int)      int_flag <= 1'b1;
            else if (clr_int) int_flag <= 1'b0;
        end
    end

    assign irq = int_flag;

    AST_INT_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag) |-> end_flag);  // R7
endmodule

// File: rtl/cb_chain_dma.sv
module cb_chain_dma
    import cbd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          start,
    input  logic          cb_addr_wr,
    input  logic [AW-1:0] cb_addr_in,
    input  logic          clr_end,
    input  logic          clr_int,
    output logic          active,
    output logic          paused,
    output logic          end_flag,
    output logic          int_flag,
    output logic          irq,
    output logic [AW-1:0] cur_cb_addr,
    output logic [DW-1:0] cb_info,
    output logic [DW-1:0] cb_src,
    output logic [DW-1:0] cb_dst,
    output logic [DW-1:0] cb_len,
    output logic [DW-1:0] cb_stride,
    output logic [DW-1:0] cb_next,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic          xfer_start,
    input  logic          xfer_done
);
    seq_state_e state, state_nx;

    logic                        proceed;
    logic                        fetch_go;
    logic                        fetch_done;
    logic [CB_WORDS-1:0][DW-1:0] words;
    logic                        set_end, set_int;

    assign proceed = chan_en && (cur_cb_addr != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)      state_nx = ST_CHECK;
            ST_CHECK:  state_nx = proceed ? ST_FETCH : ST_IDLE;
            ST_FETCH:  if (fetch_done) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_WAIT;
            ST_WAIT:   if (xfer_done)  state_nx = ST_RETIRE;
            ST_RETIRE: state_nx = ST_CHECK;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        fetch_go   = 1'b0;
        xfer_start = 1'b0;
        set_end    = 1'b0;
        set_int    = 1'b0;
        unique case (state)
            ST_CHECK:  fetch_go   = proceed;
            ST_LAUNCH: xfer_start = 1'b1;
            ST_RETIRE: begin
                set_end = 1'b1;
                set_int = cb_info[0];
            end
            default: ;
        endcase
    end

    // channel status and descriptor pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active      <= 1'b0;
            paused      <= 1'b0;
            cur_cb_addr <= '0;
        end else begin
            if (state == ST_IDLE) begin
                if (cb_addr_wr) cur_cb_addr <= cb_addr_in;
                if (start) begin
                    active <= 1'b1;
                    paused <= 1'b0;
                end
            end
            if (state == ST_CHECK && !proceed) begin
                active <= 1'b0;
                paused <= 1'b1;
            end
            if (state == ST_RETIRE) cur_cb_addr <= cb_next;
        end
    end

    cbd_fetch #(.AW(AW), .DW(DW), .NW(CB_WORDS)) i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (fetch_go),
        .base       (cur_cb_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .done       (fetch_done),
        .words      (words)
    );

    cbd_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_end  (set_end),
        .set_int  (set_int),
        .clr_end  (clr_end),
        .clr_int  (clr_int),
        .end_flag (end_flag),
        .int_flag (int_flag),
        .irq      (irq)
    );

    assign cb_info   = words[W_INFO];
    assign cb_src    = words[W_SRC];
    assign cb_dst    = words[W_DST];
    assign cb_len    = words[W_LEN];
    assign cb_stride = words[W_STRIDE];
    assign cb_next   = words[W_NEXT];
    assign mem_we    = 1'b0;
    assign mem_wdata = '0;

    AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);  // R5
    AST_STOP_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> paused);  // R10
    AST_NO_REQ_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);  // R9
    AST_IRQ_FROM_INFO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cb_info[0]));  // R7
endmodule

// File: tb/test_cb_chain_dma.sv
module test_cb_chain_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b1, start = 1'b0, cb_addr_wr = 1'b0;
    logic [31:0] cb_addr_in = '0;
    logic        clr_end = 1'b0, clr_int = 1'b0;
    logic        active, paused, end_flag, int_flag, irq;
    logic [31:0] cur_cb_addr, cb_info, cb_src, cb_dst, cb_len, cb_stride, cb_next;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        xfer_start, xfer_done = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cb_chain_dma i_cb_chain_dma (.*);

    // memory model: 256 words, one-cycle read latency
    logic [31:0] mem [0:255];
    logic [31:0] fetch_q[$];
    int          we_seen = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[9:2]];
            fetch_q.push_back(mem_addr);
            if (mem_we) we_seen++;
        end
    end

    // transfer generator model
    int          xfer_delay = 2;
    int          xcnt = 0;
    bit          xbusy = 0;
    logic [31:0] par_q[$];
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_start) begin
            par_q.push_back(cb_info);   par_q.push_back(cb_src);
            par_q.push_back(cb_dst);    par_q.push_back(cb_len);
            par_q.push_back(cb_stride); par_q.push_back(cb_next);
            xcnt  <= xfer_delay;
            xbusy <= 1;
        end else if (xbusy) begin
            if (xcnt == 0) begin
                xfer_done <= 1'b1;
                xbusy     <= 0;
            end else xcnt <= xcnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        @(negedge clk); cb_addr_wr = 1'b1; cb_addr_in = a;
        @(negedge clk); cb_addr_wr = 1'b0;
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 3000 && active; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] desc_addr(input int k);
        return 32'(k) * 32'd32;
    endfunction

    // blocks[i] is placed at slot base+i; last links to zero
    logic [31:0] exp_words[$];
    function automatic bit build_chain(input int base, input int n);
        bit any_int = 0;
        exp_words.delete();
        for (int i = 0; i < n; i++) begin
            logic [31:0] w [6];
            w[0] = $urandom;
            w[1] = $urandom; w[2] = $urandom; w[3] = $urandom; w[4] = $urandom;
            w[5] = (i == n - 1) ? 32'd0 : desc_addr(base + i + 1);
            if (w[0][0]) any_int = 1;
            for (int j = 0; j < 6; j++) begin
                mem[(base + i) * 8 + j] = w[j];
                exp_words.push_back(w[j]);
            end
        end
        return any_int;
    endfunction

    task automatic clear_flags();
        pulse(clr_end);
        pulse(clr_int);
    endtask

    task automatic run_chain(input int base, input int n);
        bit exp_irq;
        exp_irq = build_chain(base, n);
        clear_flags();
        fetch_q.delete(); par_q.delete();
        xfer_delay = $urandom_range(0, 5);
        set_addr(desc_addr(base));
        pulse(start);
        wait_stop();
        check(fetch_q.size() == 6 * n, "R3 read count", fetch_q.size(), 6 * n);
        for (int i = 0; i < fetch_q.size() && i < 6 * n; i++)
            check(fetch_q[i] == desc_addr(base + i / 6) + 32'(4 * (i % 6)),
                  "R3 read address", fetch_q[i], desc_addr(base + i / 6) + 32'(4 * (i % 6)));
        check(par_q.size() == 6 * n, "R5 kick count", par_q.size(), 6 * n);
        for (int i = 0; i < par_q.size() && i < 6 * n; i++)
            check(par_q[i] == exp_words[i], "R4 field value", par_q[i], exp_words[i]);
        check(cur_cb_addr == 32'd0, "R8 final pointer", cur_cb_addr, 0);
        check(!active && paused, "R10 stop state", {active, paused}, 2'b01);
        check(end_flag == 1'b1, "R6 end flag", end_flag, 1);
        check(irq == exp_irq && int_flag == exp_irq, "R7 irq", irq, exp_irq);
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!finished) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({active, paused, end_flag, int_flag, irq, mem_req, xfer_start} == '0,
              "R1 reset outputs", {active, paused, end_flag, int_flag, irq}, 0);
        check(cur_cb_addr == 0, "R1 reset pointer", cur_cb_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 start sets active, clears paused
        build_chain(2, 1);
        set_addr(desc_addr(2));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(active && !paused, "R2 start", {active, paused}, 2'b10);
        // R2 pointer write ignored while active
        for (int i = 0; i < 200 && !xbusy; i++) @(negedge clk);
        @(negedge clk); cb_addr_wr = 1'b1; cb_addr_in = 32'h0000_0300;
        @(negedge clk); cb_addr_wr = 1'b0;
        check(cur_cb_addr == desc_addr(2), "R2 write ignored", cur_cb_addr, desc_addr(2));
        wait_stop();
        check(cur_cb_addr == 0 && paused, "R8 single block end", cur_cb_addr, 0);

        // directed: forced interrupt-enable block
        mem[5 * 8] = 32'h1;
        mem[5 * 8 + 5] = 0;
        clear_flags();
        set_addr(desc_addr(5));
        pulse(start);
        wait_stop();
        check(irq && int_flag, "R7 irq set", irq, 1);
        // R11 clears
        pulse(clr_int);
        @(negedge clk);
        check(!irq && !int_flag && end_flag, "R11 clear int", {end_flag, irq}, 2'b10);
        pulse(clr_end);
        @(negedge clk);
        check(!end_flag, "R11 clear end", end_flag, 0);

        // directed: interrupt enable clear leaves flags clear
        mem[5 * 8] = 32'h2;
        set_addr(desc_addr(5));
        pulse(start);
        wait_stop();
        check(!irq && end_flag, "R7 no irq without bit0", {end_flag, irq}, 2'b10);

        // R9 disabled at start: nothing fetched
        fetch_q.delete();
        chan_en = 1'b0;
        set_addr(desc_addr(5));
        pulse(start);
        wait_stop();
        check(fetch_q.size() == 0, "R9 disabled no fetch", fetch_q.size(), 0);
        check(paused && !active, "R10 paused when disabled", {active, paused}, 2'b01);
        chan_en = 1'b1;

        // zero pointer at start
        fetch_q.delete();
        set_addr(32'd0);
        pulse(start);
        wait_stop();
        check(fetch_q.size() == 0, "R8 null start no fetch", fetch_q.size(), 0);

        // R9 enable dropped during first block: that block completes, chain stops
        build_chain(10, 3);
        clear_flags();
        fetch_q.delete(); par_q.delete();
        xfer_delay = 4;
        set_addr(desc_addr(10));
        pulse(start);
        for (int i = 0; i < 200 && !xbusy; i++) @(negedge clk);
        chan_en = 1'b0;
        wait_stop();
        check(par_q.size() == 6, "R9 block completes", par_q.size(), 6);
        check(fetch_q.size() == 6, "R9 no further fetch", fetch_q.size(), 6);
        check(end_flag, "R6 end after drop", end_flag, 1);
        check(cur_cb_addr == desc_addr(11), "R8 pointer followed", cur_cb_addr, desc_addr(11));
        chan_en = 1'b1;

        // random chains
        for (int t = 0; t < 12; t++)
            run_chain($urandom_range(1, 20), $urandom_range(1, 4));

        check(we_seen == 0, "R3 reads only", we_seen, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule